// File: doc/BRIEF.md
# Interrupt Acknowledge Responder with Daisy Chain

This block raises and answers interrupts for a two-channel serial controller. Eight interrupt sources feed it, each with a flag and an enable: for each of channels A and B there is a receive, a transmit, a status and an external-change source. Whenever at least one source is both flagged and enabled, the block pulls its active-low interrupt request line low. The request output is meant as an open-drain pull-down. A low value on `irqN` means the pad is driven low.

When the CPU runs an interrupt acknowledge cycle, it holds the active-low `iackN` strobe low. The block then places one of four responses on the 8-bit data bus, chosen by a configuration field:
- nothing (high impedance),
- a vector byte, either as programmed or with its low bits replaced by the code of the winning source,
- a call opcode,
- zero.

The bus is driven during the acknowledge regardless of chip select, so no chip-select input exists. The winning source is captured when the acknowledge starts and is held for the whole cycle. If nothing here is pending, the block answers nothing. Instead, when daisy chaining is enabled, it passes the acknowledge down the chain to lower-priority devices.

Top module: `irq_ack_responder`

## Requirements
- R1: `irqN` is 0 exactly when some bit of `srcFlag & srcEnable` is 1, and follows those inputs without a clock.
- R2: An acknowledge that starts while no enabled source is flagged leaves `dataOe` at 0 and `dataOut` at 0x00 for the whole cycle.
- R3: With `respMode` = 2'b00 (high impedance), `dataOe` stays 0 even when a source is pending.
- R4: With `respMode` = 2'b01 and `statusMod` = 0, a hit drives `dataOe` = 1 and `dataOut` = `baseVector`.
- R5: With `respMode` = 2'b01 and `statusMod` = 1, `dataOut` is `baseVector[7:3]` with bits [2:0] replaced by the lowest pending index. Bit 0 is A receive, bit 1 A transmit, bit 2 A status, bit 3 A external, and bits 4 to 7 are the same four sources for channel B. A lower index has higher priority.
- R6: With `respMode` = 2'b10, a hit drives `dataOut` = 0xCD.
- R7: With `respMode` = 2'b11, a hit drives `dataOut` = 0x00 with `dataOe` = 1.
- R8: The pending set and the winning source are captured at the first clock edge that sees `iackN` low. Changes to the flags or enables during the cycle do not alter `dataOe`, `dataOut` or `idcN` until `iackN` returns high.
- R9: `idcN` is 0 only while an acknowledge is active, `chainEn` = 1, and nothing was pending at capture.
- R10: With `chainEn` = 0, `idcN` stays 1.
- R11: The response appears after the first rising clock edge at which `iackN` is sampled low. It ends after the first edge at which `iackN` is sampled high. While no acknowledge is active, `dataOe` = 0, `dataOut` = 0x00 and `idcN` = 1.
- R12: `rstN` low clears the acknowledge state at once, without a clock, so that `dataOe` = 0 and `idcN` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcFlag | input | 8 | Per-source interrupt flags |
| srcEnable | input | 8 | Per-source interrupt enables |
| respMode | input | 2 | Acknowledge response: 00 none, 01 vector, 10 call, 11 zero |
| statusMod | input | 1 | Fold the winning source into vector bits [2:0] |
| baseVector | input | 8 | Programmed vector byte |
| chainEn | input | 1 | Enable the daisy-chain output |
| iackN | input | 1 | Active-low interrupt acknowledge |
| irqN | output | 1 | Active-low interrupt request (open-drain pull-down) |
| dataOut | output | 8 | Byte presented on the bus during acknowledge |
| dataOe | output | 1 | Bus drive enable |
| idcN | output | 1 | Active-low acknowledge passed down the chain |

## Verification
The bench changes the flags and enables in the middle of an acknowledge. A design that samples the sources live, instead of capturing them, would change the vector or release the chain partway through a cycle. It uses pending sets that contain several bits, so that a priority encoder that picks the highest index instead of the lowest gives the wrong vector code. It runs an acknowledge with nothing pending, with daisy chaining both on and off. A design that drives the bus anyway would show `dataOe` high, and one that forwards regardless of pending state would pull `idcN` low wrongly. It pulses reset with no clock edge while an acknowledge is active, which exposes a reset that was made synchronous.

// File: rtl/irq_resp_pkg.sv
package irq_resp_pkg;

  typedef enum logic [1:0] {
    RESP_HIZ    = 2'b00,
    RESP_VECTOR = 2'b01,
    RESP_CALL   = 2'b10,
    RESP_ZERO   = 2'b11
  } respMode_e;

  // strobes from the acknowledge control to the vector datapath
  typedef struct packed {
    logic capture;  // acknowledge just seen: snapshot the sources
    logic drop;     // acknowledge just released
    logic active;   // acknowledge cycle in progress
  } ackStrobe_t;

endpackage

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_resp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       iackN,
  input  logic       chainEn,
  input  logic       latchHit,
  output ackStrobe_t strb,
  output logic       idcN
);

  logic ackActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ackActive <= 1'b0;
    else       ackActive <= !iackN;
  end

  always_comb begin
    strb.capture = !iackN && !ackActive;
    strb.drop    = iackN && ackActive;
    strb.active  = ackActive;
  end

  // forward the acknowledge only when nothing local was pending
  assign idcN = !(chainEn && ackActive && !latchHit);

  a_r9_chain_only_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !idcN |-> !latchHit);

  a_r10_chain_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !chainEn |-> idcN);

endmodule

// File: rtl/irq_vec_datapath.sv
module irq_vec_datapath
  import irq_resp_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 8,
  parameter logic [DATA_W-1:0] CALL_CODE = 8'hCD,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcFlag,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic [1:0]         respMode,
  input  logic               statusMod,
  input  logic [DATA_W-1:0]  baseVector,
  input  ackStrobe_t         strb,
  output logic               irqN,
  output logic               latchHit,
  output logic [DATA_W-1:0]  dataOut,
  output logic               dataOe
);

  logic [NUM_SRC-1:0] pendVec;
  logic [IDX_W-1:0]   winIdx;
  logic [IDX_W-1:0]   latchIdx;
  logic [DATA_W-1:0]  vecByte;
  respMode_e          modeSel;

  assign pendVec = srcFlag & srcEnable;
  assign irqN    = !(|pendVec);
  assign modeSel = respMode_e'(respMode);

  // lowest index wins
  always_comb begin
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendVec[i]) winIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchHit <= 1'b0;
      latchIdx <= '0;
    end else if (strb.capture) begin
      latchHit <= |pendVec;
      latchIdx <= winIdx;
    end else if (strb.drop) begin
      latchHit <= 1'b0;
    end
  end

  generate
    if (DATA_W > IDX_W) begin : g_fold
      assign vecByte = statusMod ? {baseVector[DATA_W-1:IDX_W], latchIdx} : baseVector;
    end else begin : g_plain
      assign vecByte = baseVector;
    end
  endgenerate

  always_comb begin
    dataOe  = strb.active && latchHit && (modeSel != RESP_HIZ);
    dataOut = '0;
    if (dataOe) begin
      case (modeSel)
        RESP_VECTOR: dataOut = vecByte;
        RESP_CALL:   dataOut = CALL_CODE;
        default:     dataOut = '0;
      endcase
    end
  end

  a_r2_silent_without_hit: assert property (@(posedge clk) disable iff (!rstN)
    !latchHit |-> !dataOe);

  a_r3_hiz_never_drives: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == RESP_HIZ) |-> !dataOe);

  a_r8_index_held: assert property (@(posedge clk) disable iff (!rstN)
    strb.active |=> (!strb.active || $stable(latchIdx)));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !strb.active |-> (!dataOe && dataOut == '0));

endmodule

// File: rtl/irq_ack_responder.sv
module irq_ack_responder
  import irq_resp_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcFlag,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic [1:0]         respMode,
  input  logic               statusMod,
  input  logic [DATA_W-1:0]  baseVector,
  input  logic               chainEn,
  input  logic               iackN,
  output logic               irqN,
  output logic [DATA_W-1:0]  dataOut,
  output logic               dataOe,
  output logic               idcN
);

  ackStrobe_t strb;
  logic       latchHit;

  irq_ack_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .iackN    (iackN),
    .chainEn  (chainEn),
    .latchHit (latchHit),
    .strb     (strb),
    .idcN     (idcN)
  );

  irq_vec_datapath #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .srcFlag    (srcFlag),
    .srcEnable  (srcEnable),
    .respMode   (respMode),
    .statusMod  (statusMod),
    .baseVector (baseVector),
    .strb       (strb),
    .irqN       (irqN),
    .latchHit   (latchHit),
    .dataOut    (dataOut),
    .dataOe     (dataOe)
  );

endmodule

// File: tb/irq_ack_responder_tb.sv
module irq_ack_responder_tb;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] srcFlag = '0, srcEnable = '0, baseVector = 8'hA0;
  logic [1:0] respMode = 2'b01;
  logic       statusMod = 1'b0, chainEn = 1'b0, iackN = 1'b1;
  logic       irqN, dataOe, idcN;
  logic [7:0] dataOut;

  int nVec = 0, nBad = 0;
  bit mActive = 0, mHit = 0;
  int mIdx = 0;

  always #(PERIOD/2) clk = ~clk;

  irq_ack_responder u_dut (
    .clk(clk), .rstN(rstN), .srcFlag(srcFlag), .srcEnable(srcEnable),
    .respMode(respMode), .statusMod(statusMod), .baseVector(baseVector),
    .chainEn(chainEn), .iackN(iackN), .irqN(irqN), .dataOut(dataOut),
    .dataOe(dataOe), .idcN(idcN)
  );

  task automatic chk(string tag, int act, int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: compare every port against behavioural expectation
  task automatic compareAll();
    bit [7:0] pend = srcFlag & srcEnable;
    bit expOe = mActive && mHit && (respMode != 2'b00);
    int expOut = 0;
    string outTag = "R4";
    if (expOe) begin
      case (respMode)
        2'b01: begin
          expOut = statusMod ? ((baseVector & 8'hF8) | mIdx) : baseVector;
          outTag = statusMod ? "R5" : "R4";
        end
        2'b10: begin expOut = 8'hCD; outTag = "R6"; end
        default: begin expOut = 0; outTag = "R7"; end
      endcase
    end else outTag = mHit ? "R3" : "R2";
    chk("R1", irqN, (pend == 0));
    chk(mHit ? "R3" : "R2", dataOe, expOe);
    chk(outTag, dataOut, expOut);
    chk(chainEn ? "R9" : "R10", idcN, !(chainEn && mActive && !mHit));
  endtask

  task automatic tick();
    bit [7:0] pend = srcFlag & srcEnable;
    bit nIack = iackN;
    @(posedge clk);
    if (rstN) begin
      if (!nIack && !mActive) begin
        mActive = 1;
        mHit = (pend != 0);
        mIdx = 0;
        for (int i = 7; i >= 0; i--) if (pend[i]) mIdx = i;
      end else if (nIack && mActive) begin
        mActive = 0; mHit = 0;
      end
    end
    #(PERIOD/4);
    compareAll();
  endtask

  task automatic ackCycle(int holdCycles);
    iackN = 1'b0;
    #1;
    chk("R11", dataOe, 0);   // no response before the sampling edge
    repeat (holdCycles) tick();
    iackN = 1'b1;
    tick();
    tick();
  endtask

  initial begin
    #(PERIOD * 50000);
    nBad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #(PERIOD * 2 + 1);
    chk("R12", dataOe, 0);
    chk("R12", idcN, 1);
    chk("R1", irqN, 1);
    rstN = 1'b1;
    tick();

    // R1: request follows flag & enable
    srcFlag = 8'h30; srcEnable = 8'h0F; #1; chk("R1", irqN, 1);
    srcEnable = 8'h10; #1; chk("R1", irqN, 0);
    tick();

    // R2 / R9: nothing pending, chain on
    srcFlag = 8'h00; chainEn = 1'b1;
    ackCycle(3);

    // R4: plain vector, chain blocked by local hit
    srcFlag = 8'h24; srcEnable = 8'hFF; statusMod = 1'b0; baseVector = 8'h5B;
    ackCycle(2);

    // R5: status-modified vector, several patterns
    statusMod = 1'b1;
    srcFlag = 8'hA0; ackCycle(2);
    srcFlag = 8'h0C; ackCycle(2);
    srcFlag = 8'hFF; srcEnable = 8'hFE; ackCycle(2);
    srcFlag = 8'h80; srcEnable = 8'h80; baseVector = 8'hFF; ackCycle(1);

    // R6, R7, R3
    srcFlag = 8'h02; srcEnable = 8'hFF;
    respMode = 2'b10; ackCycle(2);
    respMode = 2'b11; ackCycle(2);
    respMode = 2'b00; ackCycle(2);

    // R8: sources change mid-acknowledge, response must not
    respMode = 2'b01; statusMod = 1'b1; baseVector = 8'h40;
    srcFlag = 8'h40; srcEnable = 8'hFF;
    iackN = 1'b0;
    tick();
    srcFlag = 8'h01; tick();
    chk("R8", dataOut, 8'h46);
    srcFlag = 8'h00; tick();
    chk("R8", dataOe, 1);
    chk("R8", idcN, 1);
    iackN = 1'b1; tick(); tick();

    // R8 reverse: nothing pending at capture, flag appears later
    srcFlag = 8'h00; iackN = 1'b0; tick();
    srcFlag = 8'h08; tick();
    chk("R8", idcN, 0);
    chk("R8", dataOe, 0);
    iackN = 1'b1; tick(); tick();

    // R10: chain disabled
    chainEn = 1'b0; srcFlag = 8'h00; ackCycle(2);

    // R12: asynchronous reset mid-acknowledge
    srcFlag = 8'h10; iackN = 1'b0; tick(); tick();
    #1;
    rstN = 1'b0; mActive = 0; mHit = 0;
    #1;
    chk("R12", dataOe, 0);
    chk("R12", dataOut, 0);
    iackN = 1'b1;
    chainEn = 1'b1;
    #1;
    chk("R12", idcN, 1);
    rstN = 1'b1;
    tick(); tick();

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule